// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register-mapped control and status front end for a random number generator. Software talks to it over a simple register bus: an address, a write enable, write data, and combinational read data. Writing a command word starts either a generation or a reseed. The status word shows whether the block is busy and whether it has been seeded. After a generation, a 128-bit or 256-bit result can be read from eight 32-bit result words.

Three interrupt causes exist: result ready, reseed done and generator lockup. Each cause can be masked, and software clears a cause by writing 1 to its bit. The block can also schedule reseeds by itself. One trigger counts generate requests. The other is a countdown age timer.

A seedable 32-bit Galois LFSR stands in for the entropy source and the generator core. This keeps every result predictable. A reseed XORs a software-supplied seed word into the generator state.

Top module: `rng_ctl`

## Requirements
- R1: After reset, every register reads as zero except the following. Status reads 0x00000008 and mode reads 0x00000008, so the 256-bit width is selected. The LFSR state is 0x00000001.
- R2: A write to the command register at 0x00 acts only on two values. The value 1 starts a generation and the value 2 starts a reseed. Any other value, including 0, changes nothing.
- R3: Status bit 30 is 1 for exactly 8 cycles after a generation is accepted. Status bit 31 is 1 for exactly 32 cycles after a reseed starts. A command written while either bit is 1 is dropped and leaves both bits unchanged.
- R4: Status bit 9 becomes 1 when the first reseed completes and stays 1 after that. Status bit 3 always equals mode register bit 3 (address 0x08).
- R5: One LFSR step is `next = (s >> 1) ^ (s[0] ? 0x80200003 : 0)`. A generation takes 8 steps, and result word k (at address 0x20 + 4k) receives the state reached after step k+1. When mode bit 3 is 0, words 4 to 7 are written with 0 instead.
- R6: At the end of a reseed, the new state is the old state XOR the seed word held at address 0x0C. If the old state is all zero, the new state is 0x12345679 instead.
- R7: If a reseed leaves a nonzero state equal to zero after the XOR, interrupt status bit 4 (lockup) is set.
- R8: Interrupt status is at address 0x14. Bit 0 is set when a generation ends and bit 1 is set when a reseed ends. Writing 1 to a bit clears it. If a set event and a clear for the same bit fall in the same cycle, the bit stays set.
- R9: Interrupt enable is at address 0x10. Bits 0, 1 and 4 gate the matching causes, and bit 31 is the global enable. `irq` is 1 exactly when bit 31 is 1 and some enabled cause is pending.
- R10: A nonzero value written to the request reload register at 0x60 loads the request counter. Each accepted generation decrements the counter. When a generation ends with the counter at zero, a reseed starts on the next cycle. A reload value of 0 disables this trigger.
- R11: A nonzero value written to the age reload register at 0x64 loads the age timer. The timer decrements once per clock. While the timer is at zero and the block is idle, a reseed starts, unless a software command starts in that same cycle. A reload value of 0 disables the timer.
- R12: Every reseed completion reloads both counters from their reload registers, whatever started the reseed. A write to a reload register in the same cycle takes priority over this reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check four kinds of behaviour on every cycle:
- The two busy phases never overlap, and a command written during a reseed is dropped.
- Each completion sets its cause bit, and a write-one-to-clear takes effect.
- The lockup recovery state is loaded when a reseed starts from an all-zero state.
- The age timer starts a reseed when it expires while the block is idle.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model predicts every register. These scenarios cover the exact LFSR result words in both widths, the request-count trigger firing after the configured number of generations, counter reloads, and the cycle-exact width of the busy windows.

// File: rtl/rng_ctl.sv
module rng_ctl #(
  parameter int          SEED_CYCLES   = 32,
  parameter logic [31:0] RESET_STATE   = 32'h0000_0001,
  parameter logic [31:0] RECOVER_STATE = 32'h1234_5679,
  parameter logic [31:0] POLY          = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int NWORDS = 8;
  localparam int GCW    = $clog2(NWORDS);
  localparam int SCW    = $clog2(SEED_CYCLES);
  localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_MODE = 8'h08, A_SEED = 8'h0C,
                         A_IEN = 8'h10, A_IST  = 8'h14, A_REQ  = 8'h60, A_AGE  = 8'h64;

  logic            gen_busy, seed_busy, wide, seeded, ie_glb;
  logic [GCW-1:0]  gcnt;
  logic [SCW-1:0]  scnt;
  logic [31:0]     lfsr, seedw;
  logic [31:0]     words [NWORDS];
  logic [2:0]      ie_en, ist;
  logic [15:0]     req_rl, req_c, age_rl, age_c;

  wire idle          = !gen_busy && !seed_busy;
  wire wr_cmd        = wr_en && addr == A_CMD;
  wire start_gen     = idle && wr_cmd && wr_data == 32'd1;
  wire start_sw_seed = idle && wr_cmd && wr_data == 32'd2;
  wire age_fire      = idle && !start_gen && !start_sw_seed && age_rl != 16'd0 && age_c == 16'd0;
  wire gen_last      = gen_busy && gcnt == GCW'(NWORDS - 1);
  wire seed_last     = seed_busy && scnt == SCW'(SEED_CYCLES - 1);
  wire req_fire      = gen_last && req_rl != 16'd0 && req_c == 16'd0;
  wire seed_start    = start_sw_seed || age_fire || req_fire;

  wire [31:0] lfsr_nx  = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? POLY : 32'd0);
  wire [31:0] mixed    = lfsr ^ seedw;
  wire [31:0] reseeded = (lfsr == 32'd0) ? RECOVER_STATE : mixed;
  wire        lock_evt = seed_last && lfsr != 32'd0 && mixed == 32'd0;

  wire [2:0] ist_set = {lock_evt, seed_last, gen_last};
  wire [2:0] ist_clr = (wr_en && addr == A_IST) ? {wr_data[4], wr_data[1], wr_data[0]} : 3'b000;

  assign irq = ie_glb && |(ist & ie_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_busy  <= 1'b0;
      seed_busy <= 1'b0;
      gcnt      <= '0;
      scnt      <= '0;
      lfsr      <= RESET_STATE;
      seeded    <= 1'b0;
      ist       <= 3'b000;
    end else begin
      if (start_gen) begin
        gen_busy <= 1'b1;
        gcnt     <= '0;
      end else if (gen_busy) begin
        gcnt <= gcnt + 1'b1;
        if (gen_last) gen_busy <= 1'b0;
      end
      if (seed_start) begin
        seed_busy <= 1'b1;
        scnt      <= '0;
      end else if (seed_busy) begin
        scnt <= scnt + 1'b1;
        if (seed_last) seed_busy <= 1'b0;
      end
      if (gen_busy)       lfsr <= lfsr_nx;
      else if (seed_last) lfsr <= reseeded;
      if (seed_last) seeded <= 1'b1;
      ist <= (ist & ~ist_clr) | ist_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= 32'd0;
    end else if (gen_busy) begin
      for (int i = 0; i < NWORDS; i++)
        if (gcnt == GCW'(i)) words[i] <= (wide || i < NWORDS / 2) ? lfsr_nx : 32'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide   <= 1'b1;
      seedw  <= 32'd0;
      ie_en  <= 3'b000;
      ie_glb <= 1'b0;
      req_rl <= 16'd0;
      age_rl <= 16'd0;
      req_c  <= 16'd0;
      age_c  <= 16'd0;
    end else begin
      if (wr_en && addr == A_MODE) wide <= wr_data[3];
      if (wr_en && addr == A_SEED) seedw <= wr_data;
      if (wr_en && addr == A_IEN) begin
        ie_en  <= {wr_data[4], wr_data[1], wr_data[0]};
        ie_glb <= wr_data[31];
      end
      if (wr_en && addr == A_REQ) req_rl <= wr_data[15:0];
      if (wr_en && addr == A_AGE) age_rl <= wr_data[15:0];

      if (wr_en && addr == A_REQ)          req_c <= wr_data[15:0];
      else if (seed_last)                  req_c <= req_rl;
      else if (start_gen && req_c != 16'd0) req_c <= req_c - 16'd1;

      if (wr_en && addr == A_AGE)                    age_c <= wr_data[15:0];
      else if (seed_last)                            age_c <= age_rl;
      else if (age_rl != 16'd0 && age_c != 16'd0)    age_c <= age_c - 16'd1;
    end
  end

  always_comb begin
    rd_data = 32'd0;
    case (addr)
      A_STAT: rd_data = {seed_busy, gen_busy, 20'd0, seeded, 5'd0, wide, 3'd0};
      A_MODE: rd_data = {28'd0, wide, 3'd0};
      A_SEED: rd_data = seedw;
      A_IEN:  rd_data = {ie_glb, 26'd0, ie_en[2], 2'd0, ie_en[1:0]};
      A_IST:  rd_data = {27'd0, ist[2], 2'd0, ist[1:0]};
      A_REQ:  rd_data = {16'd0, req_rl};
      A_AGE:  rd_data = {16'd0, age_rl};
      default:
        if (addr[7:5] == 3'b001 && addr[1:0] == 2'b00) rd_data = words[addr[4:2]];
    endcase
  end

  a_r3_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_busy && seed_busy));
  a_r3_cmd_dropped_in_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_busy && !seed_last && wr_cmd) |=> (seed_busy && !gen_busy));
  a_r8_ready_on_gen_end: assert property (@(posedge clk) disable iff (!rst_n)
    gen_last |=> ist[0]);
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IST && wr_data[1] && !seed_last) |=> !ist[1]);
  a_r4_seeded_after_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    seed_last |=> (seeded && ist[1]));
  a_r6_recover_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_last && lfsr == 32'd0) |=> lfsr == RECOVER_STATE);
  a_r11_age_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !wr_en && age_rl != 16'd0 && age_c == 16'd0) |=> seed_busy);
endmodule

// File: tb/rng_ctl_bench.sv
module rng_ctl_bench;
  localparam logic [31:0] POLY = 32'h8020_0003;
  localparam logic [31:0] REC  = 32'h1234_5679;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rng_ctl u_rng_ctl (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                     .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  // behavioural reference model
  logic [31:0] m_lfsr = 32'd1, m_seedw = 32'd0, m_ie = 32'd0, m_ist = 32'd0;
  logic [31:0] m_w [8];
  bit          m_wide = 1'b1, m_seeded = 1'b0;
  int          gen_left = 0, seed_left = 0;
  int          m_reqrl = 0, m_reqc = 0, m_agerl = 0, m_agec = 0;

  initial for (int i = 0; i < 8; i++) m_w[i] = 32'd0;

  function automatic logic [31:0] step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? POLY : 32'd0);
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h04: return {seed_left > 0, gen_left > 0, 20'd0, m_seeded, 5'd0, m_wide, 3'd0};
      8'h08: return m_wide ? 32'd8 : 32'd0;
      8'h0C: return m_seedw;
      8'h10: return m_ie;
      8'h14: return m_ist;
      8'h60: return m_reqrl;
      8'h64: return m_agerl;
      default: if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) return m_w[(a - 8'h20) / 4];
    endcase
    return 32'd0;
  endfunction

  function automatic bit m_irq();
    return m_ie[31] && ((m_ist & m_ie & 32'h13) != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = 32'd1; m_seedw = 0; m_ie = 0; m_ist = 0; m_wide = 1; m_seeded = 0;
      gen_left = 0; seed_left = 0; m_reqrl = 0; m_reqc = 0; m_agerl = 0; m_agec = 0;
      for (int i = 0; i < 8; i++) m_w[i] = 32'd0;
    end else begin
      logic [31:0] setb, clrb;
      int old_age;
      setb = 0;
      clrb = (wr_en && addr == 8'h14) ? (wr_data & 32'h13) : 32'd0;
      old_age = m_agec;
      if (m_agerl != 0 && m_agec != 0) m_agec--;
      if (gen_left > 0) begin
        int k;
        k = 8 - gen_left;
        m_lfsr = step(m_lfsr);
        m_w[k] = (m_wide || k < 4) ? m_lfsr : 32'd0;
        gen_left--;
        if (gen_left == 0) begin
          setb[0] = 1'b1;
          if (m_reqrl != 0 && m_reqc == 0) seed_left = 32;
        end
      end else if (seed_left > 0) begin
        seed_left--;
        if (seed_left == 0) begin
          if (m_lfsr == 0) m_lfsr = REC;
          else begin
            m_lfsr = m_lfsr ^ m_seedw;
            if (m_lfsr == 0) setb[4] = 1'b1;
          end
          m_seeded = 1; setb[1] = 1'b1;
          m_reqc = m_reqrl; m_agec = m_agerl;
        end
      end else begin
        if (wr_en && addr == 8'h00 && wr_data == 1) begin
          gen_left = 8;
          if (m_reqc != 0) m_reqc--;
        end else if (wr_en && addr == 8'h00 && wr_data == 2) seed_left = 32;
        else if (m_agerl != 0 && old_age == 0) seed_left = 32;
      end
      m_ist = (m_ist & ~clrb) | setb;
      if (wr_en) case (addr)
        8'h08: m_wide = wr_data[3];
        8'h0C: m_seedw = wr_data;
        8'h10: m_ie = wr_data & 32'h8000_0013;
        8'h60: begin m_reqrl = wr_data[15:0]; m_reqc = wr_data[15:0]; end
        8'h64: begin m_agerl = wr_data[15:0]; m_agec = wr_data[15:0]; end
        default: ;
      endcase
    end
  end

  // per-cycle comparison of the interrupt line (R9)
  always begin
    @(posedge clk); #5;
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq()) begin
        fails++;
        $display("FAIL R9 irq at %0t: actual %0b expected %0b", $time, irq, m_irq());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); addr = a; #2;
    checks++;
    if (rd_data !== mread(a)) begin
      fails++;
      $display("FAIL %s addr 0x%02h: actual 0x%08h expected 0x%08h", tag, a, rd_data, mread(a));
    end
  endtask

  task automatic expect_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (gen_left > 0 || seed_left > 0) @(negedge clk);
  endtask

  task automatic rd_words(input string tag);
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4 * i), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(8'h04, "R1"); expect_val(rd_data, 32'h8, "R1 status");
    rd(8'h08, "R1"); rd(8'h14, "R1"); rd(8'h10, "R1"); rd(8'h20, "R1"); rd(8'h60, "R1");

    // R9 enables
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R9");

    // R2/R6/R4 first reseed
    wr(8'h0C, 32'hC0FF_EE11); wr(8'h00, 32'd2);
    rd(8'h04, "R3"); expect_val(rd_data[31], 1, "R3 seeding busy");
    wait_idle(); rd(8'h04, "R4"); expect_val(rd_data[9], 1, "R4 seeded");
    rd(8'h14, "R8");

    // R5 256-bit generate, busy window R3
    wr(8'h00, 32'd1); rd(8'h04, "R3");
    wr(8'h00, 32'd2); rd(8'h04, "R3"); expect_val(rd_data[31], 0, "R3 dropped cmd");
    wait_idle(); rd_words("R5");
    // R8 write-one-to-clear
    wr(8'h14, 32'h0000_0001); rd(8'h14, "R8");
    wr(8'h14, 32'h0000_0013); rd(8'h14, "R8");

    // R5 128-bit width, R4 mirror
    wr(8'h08, 32'd0); rd(8'h04, "R4"); expect_val(rd_data[3], 0, "R4 mirror");
    wr(8'h00, 32'd1); wait_idle(); rd_words("R5");
    wr(8'h08, 32'd8);

    // R2 ignored values
    wr(8'h00, 32'd3); rd(8'h04, "R2"); wr(8'h00, 32'd0); rd(8'h04, "R2");
    wr(8'h00, 32'h101); rd(8'h04, "R2"); expect_val(rd_data[31:30], 0, "R2 idle");

    // R9 global gate off
    wr(8'h10, 32'h0000_0013); wr(8'h00, 32'd1); wait_idle(); rd(8'h14, "R9");
    wr(8'h10, 32'h8000_0002); rd(8'h10, "R9");
    wr(8'h14, 32'h13);

    // R7 lockup and R6 recovery
    wr(8'h10, 32'h8000_0010);
    wr(8'h0C, m_lfsr); wr(8'h00, 32'd2); wait_idle();
    rd(8'h14, "R7"); expect_val(rd_data[4], 1, "R7 lockup");
    wr(8'h00, 32'd1); wait_idle(); rd_words("R7");
    wr(8'h14, 32'h10); wr(8'h00, 32'd2); wait_idle();
    wr(8'h00, 32'd1); wait_idle(); rd_words("R6");
    wr(8'h14, 32'h13);

    // R10 request-count trigger
    wr(8'h60, 32'd2); rd(8'h60, "R10");
    wr(8'h00, 32'd1); wait_idle(); rd(8'h04, "R10");
    wr(8'h00, 32'd1); repeat (9) @(negedge clk);
    rd(8'h04, "R10"); expect_val(rd_data[31], 1, "R10 auto reseed");
    wait_idle(); wr(8'h00, 32'd1); wait_idle(); rd(8'h04, "R12");
    wr(8'h00, 32'd1); wait_idle(); rd(8'h04, "R12");
    wr(8'h60, 32'd0);

    // R11 age timer and R12 reload
    wr(8'h64, 32'd40); repeat (30) @(negedge clk); rd(8'h04, "R11");
    repeat (12) @(negedge clk); rd(8'h04, "R11"); expect_val(rd_data[31], 1, "R11 age reseed");
    wait_idle(); repeat (20) @(negedge clk); rd(8'h04, "R12");
    wr(8'h00, 32'd2); wait_idle(); repeat (25) @(negedge clk); rd(8'h04, "R12");
    repeat (20) @(negedge clk); rd(8'h04, "R12");
    wr(8'h64, 32'd0); wait_idle(); repeat (60) @(negedge clk); rd(8'h04, "R11");
    rd(8'h14, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule